// File: doc/BRIEF.md
# Calendar Timekeeper with Alarm Compare

This block keeps wall-clock time and a calendar from a one-pulse-per-second tick. It holds seconds, minutes, hours, day of week, date, month and a two-digit year, and it handles month lengths and leap years. Every field is stored either as plain binary or as packed BCD. Hours are kept either in 24-hour form or in 12-hour form with a PM flag. Two control inputs choose the format.

Two copies of the time are kept. The internal copy advances on every update. The user copy drives the outputs and tracks the internal copy. While the freeze input is high, the user copy holds still and software may write it field by field. When the freeze input is released, the user copy is loaded into the internal copy, and counting resumes from the written time.

Each tick starts an update window. An update-in-progress flag is raised first. A fixed number of cycles later the time fields advance. In that same cycle a one-cycle update-ended pulse is issued, together with an alarm pulse when the new time matches the three alarm bytes. An alarm byte with both top bits set matches any value.

Top module: `rtc_calendar_core`

## Requirements
- R1: After a synchronous reset the outputs read seconds 00, minutes 00, hours 00, day of week 01, date 01, month 01, year 00. The three alarm bytes are 00, and `uip_o`, `alarm_evt_o` and `upd_end_evt_o` are low.
- R2: A tick sampled at a clock edge raises `uip_o` at that edge. The time fields change, and `uip_o` falls, UIP_LEAD edges later. Ticks that arrive while `uip_o` is high are ignored.
- R3: With `cfg_bin_i`=0 and `cfg_24h_i`=1, fields count in packed BCD: seconds and minutes 00-59 and hours 00-23. Carries ripple, so 23:59:59 goes to 00:00:00 and advances the date.
- R4: With `cfg_bin_i`=1, fields count in plain binary: seconds 0x00-0x3B, hours 0x00-0x17, date up to 0x1F, month up to 0x0C, year up to 0x63.
- R5: With `cfg_24h_i`=0, bit 7 of the hours field is the PM flag and bits 6:0 hold 1-12. 11 AM goes to 12 PM (BCD 0x92), 12 PM goes to 1 PM (0x81), and 11 PM goes to 12 AM (0x12) with a date carry. In binary mode 11 PM (0x8B) goes to 0x0C.
- R6: February has 29 days when the year value is divisible by 4 and 28 days otherwise. Months 4, 6, 9 and 11 have 30 days, and all other months have 31.
- R7: On each date carry, the day of week goes from 7 to 1 and otherwise increments. Month 12 wraps to 1 with a year carry, and year 99 wraps to 00.
- R8: Writes use `wr_sel_i` codes 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 8 seconds alarm, 9 minutes alarm and 10 hours alarm. Time writes take effect only while `set_i`=1 and are ignored otherwise. While `set_i`=1 the output fields hold still across updates, but the internal copy keeps advancing and is the copy the alarm compares against.
- R9: When `set_i` falls, the user copy is loaded into the internal copy. The next update therefore advances from the user copy, not from the time the internal copy reached while frozen.
- R10: On each update `alarm_evt_o` pulses for one cycle when the new seconds, minutes and hours all match their alarm bytes. An alarm byte in the range 0xC0-0xFF matches any value of its field. Alarm writes are accepted whatever the level of `set_i`.
- R11: `upd_end_evt_o` pulses for exactly one cycle on every update, including updates made while `set_i`=1, in the cycle the time fields change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | One-cycle pulse once per second |
| set_i | input | 1 | Freeze the user copy and enable time writes |
| cfg_bin_i | input | 1 | 1 = binary fields, 0 = packed BCD |
| cfg_24h_i | input | 1 | 1 = 24-hour form, 0 = 12-hour with PM in bit 7 |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 4 | Field select for a write |
| wr_data_i | input | 8 | Write data |
| sec_o | output | 8 | Seconds (user copy) |
| min_o | output | 8 | Minutes (user copy) |
| hour_o | output | 8 | Hours (user copy) |
| dow_o | output | 8 | Day of week, 1 = Sunday |
| date_o | output | 8 | Day of month |
| mon_o | output | 8 | Month |
| year_o | output | 8 | Two-digit year |
| uip_o | output | 1 | Update in progress |
| alarm_evt_o | output | 1 | Alarm match pulse |
| upd_end_evt_o | output | 1 | Update-ended pulse |

## Verification
The properties assume that `tick_i` is a single-cycle pulse. They also assume that every field written holds a legal value for the format selected, and that the format inputs change only under the freeze input, followed by a full rewrite of the time. The day-of-week range check relies on these assumptions, since the block does not correct illegal stored values. The stimulus switches format only with `set_i` high and rewrites all seven fields before releasing it. Every written value lies inside the ranges of R3 to R5.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hr;
    logic [7:0] dow;
    logic [7:0] date;
    logic [7:0] mon;
    logic [7:0] yr;
  } rtc_time_t;

  localparam logic [3:0] SEL_SEC  = 4'd0;
  localparam logic [3:0] SEL_MIN  = 4'd1;
  localparam logic [3:0] SEL_HR   = 4'd2;
  localparam logic [3:0] SEL_DOW  = 4'd3;
  localparam logic [3:0] SEL_DATE = 4'd4;
  localparam logic [3:0] SEL_MON  = 4'd5;
  localparam logic [3:0] SEL_YR   = 4'd6;
  localparam logic [3:0] SEL_ASEC = 4'd8;
  localparam logic [3:0] SEL_AMIN = 4'd9;
  localparam logic [3:0] SEL_AHR  = 4'd10;

  localparam rtc_time_t RTC_RST = '{sec: 8'h00, min: 8'h00, hr: 8'h00,
                                    dow: 8'h01, date: 8'h01, mon: 8'h01,
                                    yr: 8'h00};

  // stored byte -> plain value 0..99
  function automatic logic [6:0] f_dec(input logic [7:0] b, input logic bin);
    if (bin) return b[6:0];
    return 7'(b[7:4] * 4'd10) + 7'(b[3:0]);
  endfunction

  // plain value 0..99 -> stored byte
  function automatic logic [7:0] f_enc(input logic [6:0] v, input logic bin);
    if (bin) return {1'b0, v};
    return {4'(v / 7'd10), 4'(v % 7'd10)};
  endfunction

  function automatic logic [6:0] f_dim(input logic [6:0] mo, input logic [6:0] yr);
    case (mo)
      7'd2:                     return (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:  return 7'd30;
      default:                  return 7'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_cal_step.sv
module rtc_cal_step
  import rtc_cal_pkg::*;
(
  input  rtc_time_t cur_i,
  input  logic      bin_i,
  input  logic      h24_i,
  output rtc_time_t nxt_o
);

  logic [6:0] s, m, h, dw, d, mo, y, h12_in, dim;
  logic [6:0] s_n, m_n, h_n, dw_n, d_n, mo_n, y_n, h12_out;
  logic       pm;

  always_comb begin
    s      = f_dec(cur_i.sec, bin_i);
    m      = f_dec(cur_i.min, bin_i);
    dw     = f_dec(cur_i.dow, bin_i);
    d      = f_dec(cur_i.date, bin_i);
    mo     = f_dec(cur_i.mon, bin_i);
    y      = f_dec(cur_i.yr, bin_i);
    h12_in = f_dec({1'b0, cur_i.hr[6:0]}, bin_i);
    if (h24_i) h = f_dec(cur_i.hr, bin_i);
    else       h = ((h12_in == 7'd12) ? 7'd0 : h12_in) + (cur_i.hr[7] ? 7'd12 : 7'd0);
    dim = f_dim(mo, y);

    s_n = s + 7'd1; m_n = m; h_n = h; dw_n = dw; d_n = d; mo_n = mo; y_n = y;
    if (s >= 7'd59) begin
      s_n = 7'd0;
      m_n = m + 7'd1;
      if (m >= 7'd59) begin
        m_n = 7'd0;
        h_n = h + 7'd1;
        if (h >= 7'd23) begin
          h_n  = 7'd0;
          dw_n = (dw >= 7'd7) ? 7'd1 : dw + 7'd1;
          d_n  = d + 7'd1;
          if (d >= dim) begin
            d_n  = 7'd1;
            mo_n = mo + 7'd1;
            if (mo >= 7'd12) begin
              mo_n = 7'd1;
              y_n  = (y >= 7'd99) ? 7'd0 : y + 7'd1;
            end
          end
        end
      end
    end

    pm      = (h_n >= 7'd12);
    h12_out = (h_n == 7'd0) ? 7'd12 : ((h_n > 7'd12) ? h_n - 7'd12 : h_n);

    nxt_o.sec  = f_enc(s_n, bin_i);
    nxt_o.min  = f_enc(m_n, bin_i);
    nxt_o.hr   = h24_i ? f_enc(h_n, bin_i) : (f_enc(h12_out, bin_i) | {pm, 7'b0});
    nxt_o.dow  = f_enc(dw_n, bin_i);
    nxt_o.date = f_enc(d_n, bin_i);
    nxt_o.mon  = f_enc(mo_n, bin_i);
    nxt_o.yr   = f_enc(y_n, bin_i);
  end

endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int NUM = 3,
  parameter int W   = 8
) (
  input  logic [NUM-1:0][W-1:0] alm_i,
  input  logic [NUM-1:0][W-1:0] tim_i,
  output logic                  hit_o
);

  logic [NUM-1:0] fld_ok;

  for (genvar g = 0; g < NUM; g++) begin : g_fld
    // both top bits set = wildcard
    assign fld_ok[g] = (alm_i[g][W-1:W-2] == 2'b11) || (alm_i[g] == tim_i[g]);
  end

  assign hit_o = &fld_ok;

endmodule

// File: rtl/rtc_upd_seq.sv
module rtc_upd_seq #(
  parameter int LEAD = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  output logic busy_o,
  output logic apply_o
);

  localparam int CW = (LEAD > 1) ? $clog2(LEAD) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEAD - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      busy_q <= tick_i;
      cnt_q  <= '0;
    end else if (cnt_q == LAST) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o  = busy_q;
  assign apply_o = busy_q && (cnt_q == LAST);

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_cal_pkg::*;
#(
  parameter int UIP_LEAD = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       set_i,
  input  logic       cfg_bin_i,
  input  logic       cfg_24h_i,
  input  logic       wr_en_i,
  input  logic [3:0] wr_sel_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] mon_o,
  output logic [7:0] year_o,
  output logic       uip_o,
  output logic       alarm_evt_o,
  output logic       upd_end_evt_o
);

  localparam int NUM_ALM = 3;

  rtc_time_t int_q, usr_q, step_src, step_nxt;
  logic [NUM_ALM-1:0][7:0] alm_q, alm_tim;
  logic set_q, set_fall, busy, apply, alm_hit, alm_evt_q, upd_evt_q;

  assign set_fall = set_q && !set_i;
  assign step_src = set_fall ? usr_q : int_q;

  rtc_upd_seq #(.LEAD(UIP_LEAD)) u_seq (
    .clk(clk), .rst(rst), .tick_i(tick_i), .busy_o(busy), .apply_o(apply)
  );

  rtc_cal_step u_step (
    .cur_i(step_src), .bin_i(cfg_bin_i), .h24_i(cfg_24h_i), .nxt_o(step_nxt)
  );

  assign alm_tim = {step_nxt.hr, step_nxt.min, step_nxt.sec};

  rtc_alarm_cmp #(.NUM(NUM_ALM), .W(8)) u_alm (
    .alm_i(alm_q), .tim_i(alm_tim), .hit_o(alm_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      int_q     <= RTC_RST;
      usr_q     <= RTC_RST;
      alm_q     <= '0;
      set_q     <= 1'b0;
      alm_evt_q <= 1'b0;
      upd_evt_q <= 1'b0;
    end else begin
      set_q     <= set_i;
      alm_evt_q <= 1'b0;
      upd_evt_q <= 1'b0;
      if (set_fall) int_q <= usr_q;
      if (apply) begin
        int_q     <= step_nxt;
        upd_evt_q <= 1'b1;
        alm_evt_q <= alm_hit;
        if (!set_i) usr_q <= step_nxt;
      end
      if (wr_en_i) begin
        if (set_i) begin
          case (wr_sel_i)
            SEL_SEC:  usr_q.sec  <= wr_data_i;
            SEL_MIN:  usr_q.min  <= wr_data_i;
            SEL_HR:   usr_q.hr   <= wr_data_i;
            SEL_DOW:  usr_q.dow  <= wr_data_i;
            SEL_DATE: usr_q.date <= wr_data_i;
            SEL_MON:  usr_q.mon  <= wr_data_i;
            SEL_YR:   usr_q.yr   <= wr_data_i;
            default: ;
          endcase
        end
        case (wr_sel_i)
          SEL_ASEC: alm_q[0] <= wr_data_i;
          SEL_AMIN: alm_q[1] <= wr_data_i;
          SEL_AHR:  alm_q[2] <= wr_data_i;
          default: ;
        endcase
      end
    end
  end

  assign sec_o         = usr_q.sec;
  assign min_o         = usr_q.min;
  assign hour_o        = usr_q.hr;
  assign dow_o         = usr_q.dow;
  assign date_o        = usr_q.date;
  assign mon_o         = usr_q.mon;
  assign year_o        = usr_q.yr;
  assign uip_o         = busy;
  assign alarm_evt_o   = alm_evt_q;
  assign upd_end_evt_o = upd_evt_q;

endmodule

// File: rtl/rtc_calendar_core_chk.sv
module rtc_calendar_core_chk (
  input logic       clk,
  input logic       rst,
  input logic       set_i,
  input logic       wr_en_i,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] dow_o,
  input logic [7:0] date_o,
  input logic [7:0] mon_o,
  input logic [7:0] year_o,
  input logic       uip_o,
  input logic       alarm_evt_o,
  input logic       upd_end_evt_o
);

  logic [55:0] flds;
  assign flds = {sec_o, min_o, hour_o, dow_o, date_o, mon_o, year_o};

  AST_UIP_BEFORE_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(set_i) && !$stable(sec_o)) |-> $past(uip_o)); // R2

  AST_END_ON_UIP_FALL: assert property (@(posedge clk) disable iff (rst)
    upd_end_evt_o |-> $fell(uip_o)); // R11

  AST_ALARM_IN_UPDATE: assert property (@(posedge clk) disable iff (rst)
    alarm_evt_o |-> upd_end_evt_o); // R10

  AST_FROZEN_COPY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(set_i) && !$past(wr_en_i)) |-> $stable(flds)); // R8

  AST_DOW_RANGE: assert property (@(posedge clk) disable iff (rst)
    upd_end_evt_o |-> (dow_o >= 8'd1 && dow_o <= 8'd7)); // R7

endmodule

bind rtc_calendar_core rtc_calendar_core_chk u_chk (
  .clk(clk), .rst(rst), .set_i(set_i), .wr_en_i(wr_en_i),
  .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
  .date_o(date_o), .mon_o(mon_o), .year_o(year_o), .uip_o(uip_o),
  .alarm_evt_o(alarm_evt_o), .upd_end_evt_o(upd_end_evt_o)
);

// File: tb/rtc_calendar_core_test.sv
module rtc_calendar_core_test;

  localparam int LEAD = 4;
  localparam int NV   = 17;
  // {bin, h24}, start {sec,min,hr,dow,date,mon,yr}, expected after one update
  localparam logic [113:0] VEC [NV] = '{
    {2'b01, 56'h00000001010100, 56'h01000001010100},
    {2'b01, 56'h09000001010100, 56'h10000001010100},
    {2'b01, 56'h59592307311299, 56'h00000001010100},
    {2'b01, 56'h59592303280224, 56'h00000004290224},
    {2'b01, 56'h59592303280223, 56'h00000004010323},
    {2'b01, 56'h59592305290224, 56'h00000006010324},
    {2'b01, 56'h59592302300410, 56'h00000003010510},
    {2'b01, 56'h59592302300110, 56'h00000003310110},
    {2'b11, 56'h3B3B17071F0C63, 56'h00000001010100},
    {2'b11, 56'h09000001010100, 56'h0A000001010100},
    {2'b11, 56'h3B3B17011C0218, 56'h000000021D0218},
    {2'b00, 56'h59591101050620, 56'h00009201050620},
    {2'b00, 56'h59599201050620, 56'h00008101050620},
    {2'b00, 56'h59599101050620, 56'h00001202060620},
    {2'b00, 56'h59591201050620, 56'h00000101050620},
    {2'b10, 56'h3B3B8B01050614, 56'h00000C02060614},
    {2'b01, 56'h59091304150705, 56'h00101304150705}
  };
  localparam string VTAG [NV] = '{"R1 R3", "R3", "R3 R7", "R6", "R6", "R6", "R6", "R6",
                                  "R4 R7", "R4", "R4 R6", "R5", "R5", "R5", "R5", "R5", "R3"};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_i = 1'b0, set_i = 1'b0, cfg_bin_i = 1'b0, cfg_24h_i = 1'b1, wr_en_i = 1'b0;
  logic [3:0] wr_sel_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, mon_o, year_o;
  logic uip_o, alarm_evt_o, upd_end_evt_o;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  rtc_calendar_core #(.UIP_LEAD(LEAD)) uut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .set_i(set_i), .cfg_bin_i(cfg_bin_i),
    .cfg_24h_i(cfg_24h_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o), .date_o(date_o),
    .mon_o(mon_o), .year_o(year_o), .uip_o(uip_o), .alarm_evt_o(alarm_evt_o),
    .upd_end_evt_o(upd_end_evt_o)
  );

  function automatic logic [55:0] now_f();
    return {sec_o, min_o, hour_o, dow_o, date_o, mon_o, year_o};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] sel, input logic [7:0] dat);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = dat;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  // Leaves set_i low; the reload happens on the release edge
  task automatic load(input logic [1:0] mode, input logic [55:0] t);
    set_i = 1'b1; cfg_bin_i = mode[1]; cfg_24h_i = mode[0];
    for (int i = 0; i < 7; i++) wr(4'(i), t[55-8*i -: 8]);
    set_i = 1'b0;
    @(negedge clk);
  endtask

  // Returns at the first negedge after the fields change
  task automatic upd();
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    repeat (LEAD) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 fields", 64'(now_f()), 64'h00000001010100);
    chk("R1 flags", {61'd0, uip_o, alarm_evt_o, upd_end_evt_o}, 64'd0);

    // R2 timing, with an extra tick during the window
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    chk("R2 uip raised", 64'(uip_o), 64'd1);
    @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    repeat (LEAD - 3) @(negedge clk);
    chk("R2 fields before change", 64'(sec_o), 64'h00);
    chk("R2 uip still high", 64'(uip_o), 64'd1);
    @(negedge clk);
    chk("R2 fields changed", 64'(sec_o), 64'h01);
    chk("R2 uip fell", 64'(uip_o), 64'd0);
    chk("R11 end pulse", 64'(upd_end_evt_o), 64'd1);
    @(negedge clk);
    chk("R11 pulse one cycle", 64'(upd_end_evt_o), 64'd0);
    repeat (LEAD + 2) @(negedge clk);
    chk("R2 extra tick ignored", 64'(sec_o), 64'h01);

    // R8 time write without SET is ignored
    wr(4'd0, 8'h45);
    chk("R8 write ignored", 64'(sec_o), 64'h01);

    // vector table
    for (int v = 0; v < NV; v++) begin
      load(VEC[v][113:112], VEC[v][111:56]);
      upd();
      chk(VTAG[v], 64'(now_f()), 64'(VEC[v][55:0]));
    end

    // R10 alarm exact and wildcard
    load(2'b01, 56'h30201003050607);
    wr(4'd8, 8'h31); wr(4'd9, 8'h20); wr(4'd10, 8'h10);
    upd();
    chk("R10 exact match", 64'(alarm_evt_o), 64'd1);
    @(negedge clk);
    chk("R10 pulse one cycle", 64'(alarm_evt_o), 64'd0);
    upd();
    chk("R10 mismatch", 64'(alarm_evt_o), 64'd0);
    wr(4'd8, 8'h33); wr(4'd9, 8'hC0); wr(4'd10, 8'hFF);
    upd();
    chk("R10 wildcard min/hr", 64'(alarm_evt_o), 64'd1);
    wr(4'd8, 8'hC7); wr(4'd9, 8'h21); wr(4'd10, 8'hC5);
    upd();
    chk("R10 min mismatch", 64'(alarm_evt_o), 64'd0);
    wr(4'd9, 8'hE0);
    upd();
    chk("R10 all wildcard", 64'(alarm_evt_o), 64'd1);

    // R8 freeze: user holds, internal advances (seen by alarm)
    load(2'b01, 56'h40201003050607);
    wr(4'd8, 8'h41); wr(4'd9, 8'hFF); wr(4'd10, 8'hFF);
    set_i = 1'b1;
    @(negedge clk);
    upd();
    chk("R8 frozen", 64'(sec_o), 64'h40);
    chk("R11 end pulse under SET", 64'(upd_end_evt_o), 64'd1);
    chk("R8 internal advanced", 64'(alarm_evt_o), 64'd1);
    upd();
    chk("R8 still frozen", 64'(sec_o), 64'h40);
    chk("R8 internal 42 no alarm", 64'(alarm_evt_o), 64'd0);
    wr(4'd1, 8'h22);
    chk("R8 write under SET", 64'(min_o), 64'h22);

    // R9 release reloads user copy
    set_i = 1'b0;
    @(negedge clk);
    chk("R9 outputs on release", 64'({sec_o, min_o}), 64'h4022);
    upd();
    chk("R9 advance from user copy", 64'({sec_o, min_o}), 64'h4122);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule